// File: doc/BRIEF.md
# Soft Power-Down Controller

This block sits beside a small 8-bit microcontroller core and controls its soft power-down state. It watches the core's register write bus for two registers: a power control register and an I/O control register. A write that sets the power-down request bit is accepted only when no wake condition is already waiting on the external interrupt pins or the external-clock timers. Once the request is accepted, the block stops the main oscillator and the CPU clock. The core's state is kept, and timer/counters 0 and 1 keep counting from their external pins.

While the core sleeps, the block watches the interrupt flags. A programmable policy bit decides whether a flag must also be enabled in order to wake the core. After a wake event the oscillator is restarted, and a counter with a parameterised length covers the restart time. When that counter expires, the CPU clock is ungated and a one-cycle resume strobe tells the core to continue at the instruction after the one that requested power-down. A port-float option, latched when power-down is entered, sets whether ports 0 to 3 keep driving their data or go to high impedance while the core is down.

Top module: `softdown_ctrl`

## Requirements
- R1: After reset, `osc_run`, `cpu_clk_en` and `port_oe` are 1, `resume` is 0, `tmr_pin_clk` is 0, and `pwr_q` reads 0.
- R2: A write to address `PWR_ADDR` (87H) with data bit 1 (the request bit) set enters power-down when it is accepted. From the next cycle, `osc_run`, `cpu_clk_en` and `tmr_pin_clk` read 0, 0 and 1, and `pwr_q` bit 1 reads 1.
- R3: Bit 5 of the power control register is the wake policy. When it is 0, only a flag `irq_flag[i]` whose `irq_en[i]` is also 1 wakes the core. When it is 1, any raised flag wakes the core.
- R4: A wake event clears `pwr_q` bit 1 and sets `osc_run` to 1 at the next clock edge. `cpu_clk_en` stays 0 for exactly `RESTART_CYC` cycles after that edge.
- R5: When the restart count ends, `cpu_clk_en` returns to 1, and `resume` is 1 for exactly that first cycle.
- R6: Flag index mapping: 0 is external interrupt 0, 1 is timer 0, 2 is external interrupt 1, and 3 is timer 1. A request is refused when external interrupt i could wake the core (its enable bit is set, or the written policy bit 5 is 1) and its pin `ext0_pin` or `ext1_pin` is at 0. A refused request leaves `pwr_q` bit 1 at 0 and the clocks running.
- R7: A request is also refused when timer i could wake the core, that timer is in external clock mode (`t0_extclk` or `t1_extclk` is 1), its count equals all ones (FFH), and its pin is at 1. A count of FEH does not refuse the request.
- R8: Bit 0 of the I/O control register (address `IOC_ADDR`) is the float option. Its value when power-down is entered sets `port_oe`: 0 keeps `port_oe` at 1 through power-down, and 1 makes `port_oe` 0 during power-down and restart.
- R9: `port_oe` returns to 1 in the same cycle that `cpu_clk_en` returns to 1.
- R10: Register writes made while the core is not running (power-down or restart) are ignored.
- R11: Interrupt flags have no effect while the core is running.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on control clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W | Register write address |
| wr_data | input | 8 | Register write data |
| irq_flag | input | NIRQ | Interrupt flags |
| irq_en | input | NIRQ | Interrupt enables |
| ext0_pin | input | 1 | External interrupt 0 pin level |
| ext1_pin | input | 1 | External interrupt 1 pin level |
| tpin0 | input | 1 | Timer 0 external clock pin level |
| tpin1 | input | 1 | Timer 1 external clock pin level |
| t0_extclk | input | 1 | Timer 0 is in external clock mode |
| t1_extclk | input | 1 | Timer 1 is in external clock mode |
| t0_count | input | TW | Timer 0 count |
| t1_count | input | TW | Timer 1 count |
| osc_run | output | 1 | Main oscillator enable |
| cpu_clk_en | output | 1 | CPU clock gate enable |
| tmr_pin_clk | output | 1 | Timers clocked from their pins only |
| port_oe | output | 1 | Ports 0 to 3 drive their data (0 = high impedance) |
| resume | output | 1 | One-cycle strobe: CPU continues execution |
| pwr_q | output | 8 | Power control register contents |

## Verification
A wrong state value shows on `osc_run` and `cpu_clk_en` one cycle after the write or wake edge that should have moved it, so every scenario samples both outputs on that cycle. An off-by-one error in the restart counter shows as `resume` and `cpu_clk_en` rising a cycle early or late, so the bench checks the last gated cycle and the first running cycle on their own. A wrongly latched float bit, or a refusal term that is missing, shows on `port_oe` or `pwr_q` bit 1 in the first cycle after entry.

// File: rtl/softdown_ctrl.sv
module softdown_ctrl #(
  parameter int ADDR_W = 8,
  parameter logic [ADDR_W-1:0] PWR_ADDR = 8'h87,
  parameter logic [ADDR_W-1:0] IOC_ADDR = 8'hF8,
  parameter int NIRQ = 5,
  parameter int TW = 8,
  parameter int RESTART_CYC = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [7:0]        wr_data,
  input  logic [NIRQ-1:0]   irq_flag,
  input  logic [NIRQ-1:0]   irq_en,
  input  logic              ext0_pin,
  input  logic              ext1_pin,
  input  logic              tpin0,
  input  logic              tpin1,
  input  logic              t0_extclk,
  input  logic              t1_extclk,
  input  logic [TW-1:0]     t0_count,
  input  logic [TW-1:0]     t1_count,
  output logic              osc_run,
  output logic              cpu_clk_en,
  output logic              tmr_pin_clk,
  output logic              port_oe,
  output logic              resume,
  output logic [7:0]        pwr_q
);

  localparam int CW = $clog2(RESTART_CYC + 1);
  localparam logic [CW-1:0] LAST = CW'(RESTART_CYC - 1);

  typedef enum logic [1:0] {S_RUN, S_SLEEP, S_WARM} st_t;

  st_t           state;
  logic [CW-1:0] cnt;
  logic [7:0]    ioc_q;
  logic          float_hold;

  wire running = (state == S_RUN);
  wire pwr_wr  = wr_en && running && (wr_addr == PWR_ADDR);
  wire ioc_wr  = wr_en && running && (wr_addr == IOC_ADDR);

  wire [NIRQ-1:0] may_wake = irq_en | {NIRQ{wr_data[5]}};
  wire blk_e0 = may_wake[0] && !ext0_pin;
  wire blk_e1 = may_wake[2] && !ext1_pin;
  wire blk_t0 = may_wake[1] && t0_extclk && (t0_count == '1) && tpin0;
  wire blk_t1 = may_wake[3] && t1_extclk && (t1_count == '1) && tpin1;
  wire blocked  = blk_e0 | blk_e1 | blk_t0 | blk_t1;
  wire entry_ok = pwr_wr && wr_data[1] && !blocked;

  wire wake_hit = (state == S_SLEEP) &&
                  (|(irq_flag & (irq_en | {NIRQ{pwr_q[5]}})));
  wire warm_end = (state == S_WARM) && (cnt == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= S_RUN;
      cnt <= '0;
      resume <= 1'b0;
    end else begin
      resume <= warm_end;
      case (state)
        S_RUN:   if (entry_ok) state <= S_SLEEP;
        S_SLEEP: if (wake_hit) begin
                   state <= S_WARM;
                   cnt <= '0;
                 end
        S_WARM:  if (warm_end) state <= S_RUN;
                 else cnt <= cnt + 1'b1;
        default: state <= S_RUN;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pwr_q <= '0;
      ioc_q <= '0;
      float_hold <= 1'b0;
    end else begin
      if (pwr_wr) pwr_q <= {wr_data[7:2], entry_ok, wr_data[0]};
      else if (wake_hit) pwr_q[1] <= 1'b0;
      if (ioc_wr) ioc_q <= wr_data;
      if (entry_ok) float_hold <= ioc_q[0];
    end
  end

  assign osc_run     = (state != S_SLEEP);
  assign cpu_clk_en  = running;
  assign tmr_pin_clk = (state == S_SLEEP);
  assign port_oe     = running || !float_hold;

  assert_refuse_int0_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (pwr_wr && wr_data[1] && irq_en[0] && !ext0_pin) |=> (cpu_clk_en && !pwr_q[1]));

  assert_refuse_tmr0_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (pwr_wr && wr_data[1] && irq_en[1] && t0_extclk && (t0_count == '1) && tpin0)
      |=> cpu_clk_en);

  assert_wake_osc_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!osc_run && |(irq_flag & irq_en)) |=> (osc_run && !cpu_clk_en && !pwr_q[1]));

  assert_resume_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
    resume |=> !resume);

  assert_clk_resume_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cpu_clk_en) |-> resume);

  assert_port_return_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(port_oe) |-> $rose(cpu_clk_en));

  assert_run_ignores_flags_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_clk_en && !(wr_en && wr_addr == PWR_ADDR)) |=> cpu_clk_en);

endmodule

// File: tb/softdown_ctrl_tb.sv
module softdown_ctrl_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NIRQ = 5;
  localparam int RC = 16;

  logic clk = 0, rst_n = 0, wr_en = 0;
  logic [7:0] wr_addr = 0, wr_data = 0;
  logic [NIRQ-1:0] irq_flag = 0, irq_en = 0;
  logic ext0_pin = 1, ext1_pin = 1, tpin0 = 0, tpin1 = 0;
  logic t0_extclk = 0, t1_extclk = 0;
  logic [7:0] t0_count = 0, t1_count = 0;
  logic osc_run, cpu_clk_en, tmr_pin_clk, port_oe, resume;
  logic [7:0] pwr_q;
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  softdown_ctrl #(.NIRQ(NIRQ), .RESTART_CYC(RC)) u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .irq_flag(irq_flag), .irq_en(irq_en), .ext0_pin(ext0_pin), .ext1_pin(ext1_pin),
    .tpin0(tpin0), .tpin1(tpin1), .t0_extclk(t0_extclk), .t1_extclk(t1_extclk),
    .t0_count(t0_count), .t1_count(t1_count), .osc_run(osc_run), .cpu_clk_en(cpu_clk_en),
    .tmr_pin_clk(tmr_pin_clk), .port_oe(port_oe), .resume(resume), .pwr_q(pwr_q));

  task automatic chk(string req, logic [31:0] got, logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %0h expected %0h", req, got, exp);
    end
  endtask

  task automatic wr(logic [7:0] a, logic [7:0] d);
    @(negedge clk);
    wr_en = 1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 0;
  endtask

  // Raise flag idx, follow the restart sequence, check the resume cycle.
  task automatic wake(int idx, logic exp_oe_warm);
    irq_flag[idx] = 1;
    @(negedge clk);
    irq_flag = 0;
    chk("R4 osc_run after wake", osc_run, 1);
    chk("R4 pd bit cleared", pwr_q[1], 0);
    chk("R8 port_oe in restart", port_oe, exp_oe_warm);
    repeat (RC - 1) @(negedge clk);
    chk("R4 clock still gated last restart cycle", cpu_clk_en, 0);
    chk("R5 no resume before count ends", resume, 0);
    @(negedge clk);
    chk("R5 cpu clock back", cpu_clk_en, 1);
    chk("R5 resume strobe", resume, 1);
    chk("R9 port_oe with clock", port_oe, 1);
    @(negedge clk);
    chk("R5 resume one cycle", resume, 0);
  endtask

  task automatic t_reset;
    chk("R1 osc_run", osc_run, 1);
    chk("R1 cpu_clk_en", cpu_clk_en, 1);
    chk("R1 port_oe", port_oe, 1);
    chk("R1 resume", resume, 0);
    chk("R1 tmr_pin_clk", tmr_pin_clk, 0);
    chk("R1 pwr_q", pwr_q, 0);
  endtask

  task automatic t_basic;
    irq_en = 5'b10000;
    wr(8'h87, 8'h02);
    chk("R2 osc stopped", osc_run, 0);
    chk("R2 cpu gated", cpu_clk_en, 0);
    chk("R2 timers on pins", tmr_pin_clk, 1);
    chk("R2 pd bit", pwr_q, 8'h02);
    chk("R8 alf0 keeps driving", port_oe, 1);
    wake(4, 1);
    irq_en = 0;
  endtask

  task automatic t_policy;
    wr(8'h87, 8'h02);
    irq_flag[4] = 1;
    repeat (3) @(negedge clk);
    chk("R3 disabled flag no wake rpd0", osc_run, 0);
    irq_flag = 0;
    irq_en[4] = 1;
    wake(4, 1);
    irq_en = 0;
    wr(8'h87, 8'h22);
    chk("R3 entered with rpd1", cpu_clk_en, 0);
    wake(4, 1);
    chk("R3 rpd kept after wake", pwr_q, 8'h20);
    wr(8'h87, 8'h00);
  endtask

  task automatic t_refuse_int;
    irq_en = 5'b00001; ext0_pin = 0;
    wr(8'h87, 8'h02);
    chk("R6 int0 low refused clk", cpu_clk_en, 1);
    chk("R6 int0 low refused pd", pwr_q[1], 0);
    irq_en = 0;
    wr(8'h87, 8'h22);
    chk("R6 int0 low refused via policy", cpu_clk_en, 1);
    ext0_pin = 1; ext1_pin = 0; irq_en = 5'b00100;
    wr(8'h87, 8'h02);
    chk("R6 int1 low refused", osc_run, 1);
    irq_en = 0;
    wr(8'h87, 8'h02);
    chk("R6 int1 low not enabled accepted", cpu_clk_en, 0);
    irq_en = 5'b00001;
    wake(0, 1);
    ext1_pin = 1; irq_en = 0;
  endtask

  task automatic t_refuse_tmr;
    irq_en = 5'b00010; t0_extclk = 1; t0_count = 8'hFF; tpin0 = 1;
    wr(8'h87, 8'h02);
    chk("R7 timer0 FF pin1 refused", cpu_clk_en, 1);
    chk("R7 timer0 refused pd", pwr_q[1], 0);
    irq_en = 5'b01000; t1_extclk = 1; t1_count = 8'hFF; tpin1 = 1;
    wr(8'h87, 8'h02);
    chk("R7 timer1 FF pin1 refused", cpu_clk_en, 1);
    t1_count = 8'hFE;
    wr(8'h87, 8'h02);
    chk("R7 timer1 FE accepted", cpu_clk_en, 0);
    wake(3, 1);
    irq_en = 0; t0_extclk = 0; t1_extclk = 0; tpin0 = 0; tpin1 = 0;
    t0_count = 0; t1_count = 0;
  endtask

  task automatic t_float;
    irq_en = 5'b10000;
    wr(8'hF8, 8'h01);
    wr(8'h87, 8'h02);
    chk("R8 alf1 floats", port_oe, 0);
    wake(4, 0);
    wr(8'hF8, 8'h00);
    wr(8'h87, 8'h02);
    wr(8'hF8, 8'h01);
    chk("R10 ioc write in sleep ignored", port_oe, 1);
    wr(8'h87, 8'h00);
    chk("R10 pwr write in sleep ignored", pwr_q[1], 1);
    wake(4, 1);
    wr(8'h87, 8'h02);
    chk("R10 alf still 0 next sleep", port_oe, 1);
    wake(4, 1);
    irq_en = 0;
  endtask

  task automatic t_run_flags;
    irq_en = 5'b11111; irq_flag = 5'b11111;
    repeat (4) @(negedge clk);
    chk("R11 flags in run no effect", cpu_clk_en, 1);
    chk("R11 no resume in run", resume, 0);
    irq_flag = 0; irq_en = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_basic();
    t_policy();
    t_refuse_int();
    t_refuse_tmr();
    t_float();
    t_run_flags();
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
      end
    join_any
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule